// File: doc/BRIEF.md
# UART Receive Queue with Automatic Flow Control

This block is the receive-side buffer of a UART. It sits after the receive shift register. Each assembled character arrives on a write strobe with its three per-character error flags, and the pair is kept as one entry. The host sees the oldest entry's byte and flags at the head. It removes that entry with a read strobe.

A data-ready interrupt rises once the fill reaches a trigger level picked from four values. When automatic flow control is on, the block drives the active-low request-to-send line itself. It pauses the remote transmitter when the queue nears full and releases it once the queue has drained. The two thresholds sit a fixed distance above and below the interrupt trigger, and between them the line keeps its last state. With queueing disabled, the block acts as a single holding register.

Top module: `rxq_top`

## Requirements
- R1: Entries leave in arrival order. `head_data` shows the oldest byte and `head_tags` shows its flags: bit 2 break, bit 1 framing, bit 0 parity.
- R2: `fill` counts stored entries. A read and a write in the same cycle on a non-empty queue leave `fill` unchanged. A read of an empty queue is ignored, and the head keeps showing the last entry removed.
- R3: A write that arrives when the queue is at capacity, with no read in the same cycle, is dropped and sets `overrun`. `overrun` stays set until a `lsr_rd` pulse.
- R4: With `queue_en`=1, `rx_irq` is high exactly when `fill` >= trigger. `trig_sel` values 0, 1, 2 and 3 select triggers of 1, 8, 16 and 28.
- R5: With `queue_en`=0, capacity is one entry and `rx_irq` is high whenever that entry is present.
- R6: With `flow_en`=1 and `rts_req`=1, `rts_n` goes high once `fill` >= min(trigger+8, 32) and goes low once `fill` <= max(trigger-8, 1). Between those thresholds it holds its state. With `queue_en`=0 the thresholds are 1 and 0.
- R7: Unless both `flow_en` and `rts_req` are 1, `rts_n` equals the inverse of `rts_req`.
- R8: A `flush` pulse empties the queue. It shows zero byte and zero flags at the head and returns the automatic flow state to asserted (low). A write in the same cycle is discarded and `overrun` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character-complete strobe from the shift register |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Break, framing and parity flags of that byte |
| rd_en | input | 1 | Host removes the head entry |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| flush | input | 1 | Empties the queue |
| queue_en | input | 1 | 1: 32-entry queue, 0: single holding register |
| trig_sel | input | 2 | Interrupt trigger select |
| flow_en | input | 1 | Enables automatic request-to-send |
| rts_req | input | 1 | Request-to-send control bit |
| head_data | output | 8 | Byte at the head |
| head_tags | output | 3 | Flags of the head byte |
| fill | output | 6 | Number of stored entries |
| rx_irq | output | 1 | Receive-data interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench walks the flow line across both thresholds in both directions. A design without hysteresis would toggle `rts_n` at a single level, and one that compared after the wrong register would switch one character late. It drives the clamped trigger settings, 1 and 28. An unclamped threshold would either never pause the sender or release it at zero. It also covers a write into a full queue, where a wrong design would wrap and corrupt the head. It covers a simultaneous read and write, where a wrong count would drift, and a read of an empty queue, where the head would show stale memory. Flush with a concurrent write and the one-entry mode complete the set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic [TAG_W-1:0]  tags;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic       flush,
  input  logic       empty,
  input  rxq_entry_t wr_entry,
  output rxq_entry_t head_entry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_entry_t       mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  rxq_entry_t       held_q, held_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    held_d = held_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      held_d = '0;
    end else begin
      if (push) wptr_d = bump(wptr_q);
      if (pop) begin
        rptr_d = bump(rptr_q);
        held_d = mem_q[rptr_q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      held_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= wr_entry;
  end

  assign head_entry = empty ? held_q : mem_q[rptr_q];
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int HYST  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic                         lsr_rd,
  input  logic                         flush,
  input  logic                         queue_en,
  input  logic [1:0]                   trig_sel,
  output logic                         push,
  output logic                         pop,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         irq,
  output logic                         over,
  output logic                         pause
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] count_q, count_d;
  logic          over_q, over_d;
  logic          pause_q, pause_d;
  logic          room, drop;
  int            trig, cap, hi_th, lo_th;

  always_comb begin
    trig  = trig_level(trig_sel);
    cap   = queue_en ? DEPTH : 1;
    hi_th = (trig + HYST > DEPTH) ? DEPTH : trig + HYST;
    lo_th = (trig - HYST < 1) ? 1 : trig - HYST;
    if (!queue_en) begin
      hi_th = 1;
      lo_th = 0;
    end

    pop  = rd_en && (count_q != '0) && !flush;
    room = (int'(count_q) < cap) || pop;
    push = wr_en && !flush && room;
    drop = wr_en && !flush && !room;

    count_d = count_q;
    if (flush) count_d = '0;
    else if (push && !pop) count_d = count_q + 1'b1;
    else if (pop && !push) count_d = count_q - 1'b1;

    over_d = over_q;
    if (drop) over_d = 1'b1;
    else if (lsr_rd) over_d = 1'b0;

    pause_d = pause_q;
    if (flush) pause_d = 1'b0;
    else if (int'(count_d) >= hi_th) pause_d = 1'b1;
    else if (int'(count_d) <= lo_th) pause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      over_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      count_q <= count_d;
      over_q  <= over_d;
      pause_q <= pause_d;
    end
  end

  assign count = count_q;
  assign over  = over_q;
  assign pause = pause_q;
  assign irq   = queue_en ? (int'(count_q) >= trig) : (count_q != '0);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int HYST  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [TAG_W-1:0]           wr_tags,
  input  logic                       rd_en,
  input  logic                       lsr_rd,
  input  logic                       flush,
  input  logic                       queue_en,
  input  logic [1:0]                 trig_sel,
  input  logic                       flow_en,
  input  logic                       rts_req,
  output logic [DATA_W-1:0]          head_data,
  output logic [TAG_W-1:0]           head_tags,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       rx_irq,
  output logic                       rts_n,
  output logic                       overrun
);
  localparam int CW = $clog2(DEPTH+1);

  logic          push, pop, pause;
  logic [CW-1:0] count;
  rxq_entry_t    wr_entry, head_entry;

  assign wr_entry = '{tags: wr_tags, data: wr_data};

  rxq_level #(.DEPTH(DEPTH), .HYST(HYST)) level_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
    .flush(flush), .queue_en(queue_en), .trig_sel(trig_sel),
    .push(push), .pop(pop), .count(count), .irq(rx_irq), .over(overrun),
    .pause(pause)
  );

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .empty(count == '0), .wr_entry(wr_entry), .head_entry(head_entry)
  );

  assign fill      = count;
  assign head_data = head_entry.data;
  assign head_tags = head_entry.tags;
  assign rts_n     = (flow_en && rts_req) ? pause : !rts_req;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic                       lsr_rd,
  input logic                       flush,
  input logic                       queue_en,
  input logic                       flow_en,
  input logic                       rts_req,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [2:0]                 head_tags,
  input logic                       rx_irq,
  input logic                       rts_n,
  input logic                       overrun
);
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  p_rdwr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && !flush && fill != '0) |=> fill == $past(fill));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !flush && int'(fill) >= (queue_en ? DEPTH : 1))
      |=> (overrun && fill == $past(fill)));

  p_overrun_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !wr_en) |=> !overrun);

  p_single_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_en && fill != '0) |-> rx_irq);

  p_full_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && rts_req && int'(fill) == DEPTH) |-> rts_n);

  p_manual_rts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flow_en && rts_req) |-> (rts_n == !rts_req));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && head_tags == 3'd0 && overrun == $past(overrun)));
endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
  .flush(flush), .queue_en(queue_en), .flow_en(flow_en), .rts_req(rts_req),
  .fill(fill), .head_tags(head_tags), .rx_irq(rx_irq), .rts_n(rts_n),
  .overrun(overrun)
);

// File: tb/rxq_top_tb_top.sv
`timescale 1ns/1ps
module rxq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0, flush = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_tags = '0;
  logic       queue_en = 1'b1, flow_en = 1'b0, rts_req = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic [5:0] fill;
  logic       rx_irq, rts_n, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tags(wr_tags),
    .rd_en(rd_en), .lsr_rd(lsr_rd), .flush(flush), .queue_en(queue_en),
    .trig_sel(trig_sel), .flow_en(flow_en), .rts_req(rts_req),
    .head_data(head_data), .head_tags(head_tags), .fill(fill), .rx_irq(rx_irq),
    .rts_n(rts_n), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] d, input logic [2:0] t);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; wr_tags = t;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, base + 8'(i), 3'd0);
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 8'd0, 3'd0);
  endtask

  task automatic do_flush(input bit with_write);
    @(negedge clk);
    flush = 1'b1; wr_en = with_write; wr_data = 8'hFF; wr_tags = 3'd7;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset fill", int'(fill), 0);
    chk("R4 reset irq", int'(rx_irq), 0);
    chk("R3 reset overrun", int'(overrun), 0);
    chk("R7 reset rts_n", int'(rts_n), 1);
  endtask

  task automatic t_order();
    queue_en = 1'b1; trig_sel = 2'd1;
    cyc(1'b1, 1'b0, 8'h11, 3'd1);
    cyc(1'b1, 1'b0, 8'h22, 3'd2);
    cyc(1'b1, 1'b0, 8'h33, 3'd4);
    chk("R2 fill 3", int'(fill), 3);
    chk("R1 head first", int'(head_data), 'h11);
    chk("R1 tags parity", int'(head_tags), 1);
    chk("R4 below trigger", int'(rx_irq), 0);
    pop_n(1);
    chk("R1 head second", int'(head_data), 'h22);
    chk("R1 tags framing", int'(head_tags), 2);
    pop_n(2);
    chk("R2 drained", int'(fill), 0);
    chk("R2 last head held", int'(head_data), 'h33);
    chk("R2 last tags held", int'(head_tags), 4);
    pop_n(1);
    chk("R2 empty read fill", int'(fill), 0);
    chk("R2 empty read head", int'(head_data), 'h33);
    chk("R3 empty read no flag", int'(overrun), 0);
    cyc(1'b1, 1'b0, 8'h44, 3'd0);
    cyc(1'b1, 1'b1, 8'h55, 3'd0);
    chk("R2 rd+wr fill", int'(fill), 1);
    chk("R1 rd+wr head", int'(head_data), 'h55);
    do_flush(1'b0);
  endtask

  task automatic t_trig();
    queue_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 16 : 28;
      trig_sel = 2'(s);
      do_flush(1'b0);
      push_n(lvl - 1, 8'h00);
      chk("R4 one below trigger", int'(rx_irq), 0);
      push_n(1, 8'h80);
      chk("R4 at trigger", int'(rx_irq), 1);
    end
    do_flush(1'b0);
  endtask

  task automatic t_hyst();
    queue_en = 1'b1; trig_sel = 2'd2; flow_en = 1'b1; rts_req = 1'b1;
    do_flush(1'b0);
    push_n(23, 8'h00);
    chk("R6 fill 23 asserted", int'(rts_n), 0);
    push_n(1, 8'h00);
    chk("R6 fill 24 paused", int'(rts_n), 1);
    pop_n(15);
    chk("R6 fill 9 held", int'(rts_n), 1);
    pop_n(1);
    chk("R6 fill 8 resumed", int'(rts_n), 0);
    push_n(15, 8'h00);
    chk("R6 fill 23 held low", int'(rts_n), 0);
    trig_sel = 2'd3;
    do_flush(1'b0);
    push_n(31, 8'h00);
    chk("R6 clamp hi 31", int'(rts_n), 0);
    push_n(1, 8'h00);
    chk("R6 clamp hi 32", int'(rts_n), 1);
    pop_n(11);
    chk("R6 trig28 fill 21", int'(rts_n), 1);
    pop_n(1);
    chk("R6 trig28 fill 20", int'(rts_n), 0);
    trig_sel = 2'd0;
    do_flush(1'b0);
    push_n(9, 8'h00);
    chk("R6 trig1 fill 9", int'(rts_n), 1);
    pop_n(7);
    chk("R6 trig1 fill 2", int'(rts_n), 1);
    pop_n(1);
    chk("R6 clamp lo fill 1", int'(rts_n), 0);
    do_flush(1'b0);
  endtask

  task automatic t_overrun();
    queue_en = 1'b1; flow_en = 1'b0; rts_req = 1'b0;
    do_flush(1'b0);
    push_n(32, 8'h40);
    chk("R3 full", int'(fill), 32);
    cyc(1'b1, 1'b0, 8'hEE, 3'd7);
    chk("R3 drop fill", int'(fill), 32);
    chk("R3 overrun set", int'(overrun), 1);
    chk("R3 head intact", int'(head_data), 'h40);
    pop_n(1);
    chk("R3 sticky", int'(overrun), 1);
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
    chk("R3 cleared", int'(overrun), 0);
    pop_n(30);
    chk("R1 tail entry", int'(head_data), 'h5F);
    do_flush(1'b0);
  endtask

  task automatic t_single();
    queue_en = 1'b0; flow_en = 1'b1; rts_req = 1'b1;
    do_flush(1'b0);
    cyc(1'b1, 1'b0, 8'hA1, 3'd1);
    chk("R5 fill 1", int'(fill), 1);
    chk("R5 irq", int'(rx_irq), 1);
    chk("R6 single paused", int'(rts_n), 1);
    cyc(1'b1, 1'b0, 8'hA2, 3'd0);
    chk("R5 second dropped", int'(head_data), 'hA1);
    chk("R3 single overrun", int'(overrun), 1);
    pop_n(1);
    chk("R5 irq clear", int'(rx_irq), 0);
    chk("R6 single resumed", int'(rts_n), 0);
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
    queue_en = 1'b1;
    do_flush(1'b0);
  endtask

  task automatic t_manual();
    flow_en = 1'b0; rts_req = 1'b1;
    @(negedge clk);
    chk("R7 manual low", int'(rts_n), 0);
    rts_req = 1'b0;
    @(negedge clk);
    chk("R7 manual high", int'(rts_n), 1);
    flow_en = 1'b1; trig_sel = 2'd0;
    push_n(10, 8'h00);
    chk("R7 auto gated by req", int'(rts_n), 1);
    rts_req = 1'b1;
    @(negedge clk);
    chk("R6 auto paused at 10", int'(rts_n), 1);
  endtask

  task automatic t_flush();
    do_flush(1'b1);
    chk("R8 fill zero", int'(fill), 0);
    chk("R8 head zero", int'(head_data), 0);
    chk("R8 tags zero", int'(head_tags), 0);
    chk("R8 rts asserted", int'(rts_n), 0);
    chk("R8 overrun untouched", int'(overrun), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trig();
    t_hyst();
    t_overrun();
    t_single();
    t_manual();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule